// File: doc/BRIEF.md
# RS-485 Transceiver Direction Controller

This block sits next to a 16550-style UART core and decides, cycle by cycle, whether the attached half- or full-duplex line transceiver drives the bus, listens to it, or does both. It also drives the bus termination output. Software picks one of four wire modes and a global transceiver enable through a small register slice. The slice also presents a read-only port mode register and two read-only FIFO depth registers. The UART core supplies three live inputs: a "transmit FIFO not empty" flag, a "shift register busy" flag and its DTR output.

In the automatic mode a three-state machine turns the bus around without software. It starts in LISTEN. The transition `start_tx` (FIFO not empty) moves it to SEND. The transition `fifo_drained` (FIFO empty, shifter still busy) moves it from SEND to DRAIN. The transition `refill` (FIFO not empty again) moves it from DRAIN back to SEND. The transition `line_idle` (FIFO empty, shifter idle) moves it from SEND or DRAIN back to LISTEN. The transition `forced_listen` takes it to LISTEN from any state whenever the automatic mode or the global enable is not active. The driver is on in SEND and DRAIN, so the last stop bit leaves before the bus is released. The driver enable and receiver enable outputs are registered.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset the port control register reads 0x03 (automatic mode, transceiver enable clear, termination clear), and drv_en, rcv_en and term_en are 0.
- R2: With wire mode 0 (full duplex) and the enable set, drv_en and rcv_en are both 1.
- R3: With wire mode 1 (echo) and the enable set, drv_en follows dtr_in one clock later and rcv_en is 1.
- R4: With wire mode 2 (DTR direction) and the enable set, drv_en follows dtr_in one clock later and rcv_en is its inverse.
- R5: With wire mode 3 (automatic) and the enable set, drv_en rises on the first clock edge after tx_fifo_nonempty is seen high, and rcv_en is always the inverse of drv_en.
- R6: In automatic mode, once the FIFO empties, drv_en stays 1 while tx_shift_busy is 1. It falls on the first edge after both flags are low.
- R7: While port control bit 3 (transceiver enable) is clear, drv_en and rcv_en are 0 in every mode. A write that clears the bit takes effect on the outputs one edge after the write edge.
- R8: The port control register is at offset 0xF. Bits [1:0] hold the mode, bit 3 holds the enable and bit 6 holds the termination, and term_en equals bit 6. All other bits read as 0, so a write of 0xFF reads back 0x4B.
- R9: Offsets 0xC and 0xD return the TX and RX FIFO depth parameters. Writes to them, and to 0xE, change neither those registers nor the port control register.
- R10: The port mode register at offset 0xE reads the capability parameter in bits [1:0] and the current interface in bit 4 (1 = RS-485). For the dual capability (3), bit 4 equals port_is_rs485. Every other bit reads 0.
- R11: dtr_out equals drv_en when auto_dtr_en is 1 and the wire mode is 3; otherwise it equals dtr_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational on reg_addr) |
| tx_fifo_nonempty | input | 1 | UART transmit FIFO holds data |
| tx_shift_busy | input | 1 | UART transmit shifter still sending |
| dtr_in | input | 1 | DTR from the UART modem control |
| auto_dtr_en | input | 1 | Let the automatic direction drive DTR |
| port_is_rs485 | input | 1 | Interface strap for a dual-capable port |
| drv_en | output | 1 | Line driver enable |
| rcv_en | output | 1 | Receiver enable |
| term_en | output | 1 | Bus termination enable |
| dtr_out | output | 1 | DTR towards the line side |

## Verification
A change on dtr_in, tx_fifo_nonempty or tx_shift_busy reaches drv_en and rcv_en on the first rising edge after it is seen. A register write is visible on reg_rdata and term_en right after its write edge, and it reaches drv_en and rcv_en one edge later. reg_rdata and dtr_out settle combinationally. The bench drives on falling edges. In the mode sweep it waits three cycles before sampling. In the turn-around and enable tests it samples on the exact falling edge where a result is due, and on the one before it, to show the output neither comes early nor lags.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    typedef enum logic [1:0] {
        WM_FULL_DUPLEX = 2'd0,
        WM_ECHO        = 2'd1,
        WM_DTR_DIR     = 2'd2,
        WM_AUTO_DIR    = 2'd3
    } wire_mode_e;

    typedef enum logic [1:0] {
        ST_LISTEN = 2'd0,
        ST_SEND   = 2'd1,
        ST_DRAIN  = 2'd2
    } dir_state_e;

    localparam int unsigned OFS_TXDEPTH  = 12;
    localparam int unsigned OFS_RXDEPTH  = 13;
    localparam int unsigned OFS_PORTMODE = 14;
    localparam int unsigned OFS_PORTCTRL = 15;

    localparam int unsigned BIT_XCVR_EN  = 3;
    localparam int unsigned BIT_TERM     = 6;
    localparam int unsigned BIT_IFACE    = 4;

endpackage

// File: rtl/rs485_dir_regs.sv
module rs485_dir_regs
    import rs485_dir_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int TX_DEPTH = 64,
    parameter int RX_DEPTH = 32,
    parameter int PORT_CAP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              port_is_rs485,
    output wire_mode_e        wire_mode,
    output logic              xcvr_en,
    output logic              term_en
);

    localparam logic [1:0]        CAP_BITS = PORT_CAP[1:0];
    localparam logic [ADDR_W-1:0] A_TXD    = ADDR_W'(OFS_TXDEPTH);
    localparam logic [ADDR_W-1:0] A_RXD    = ADDR_W'(OFS_RXDEPTH);
    localparam logic [ADDR_W-1:0] A_PMODE  = ADDR_W'(OFS_PORTMODE);
    localparam logic [ADDR_W-1:0] A_PCTRL  = ADDR_W'(OFS_PORTCTRL);

    logic iface_rs485;

    // Only the port control register is writable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wire_mode <= WM_AUTO_DIR;
            xcvr_en   <= 1'b0;
            term_en   <= 1'b0;
        end else if (we && addr == A_PCTRL) begin
            wire_mode <= wire_mode_e'(wdata[1:0]);
            xcvr_en   <= wdata[BIT_XCVR_EN];
            term_en   <= wdata[BIT_TERM];
        end
    end

    // Current interface as reported by the port mode register
    always_comb begin
        unique case (CAP_BITS)
            2'd3:    iface_rs485 = port_is_rs485;
            2'd2:    iface_rs485 = 1'b1;
            default: iface_rs485 = 1'b0;
        endcase
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_TXD:   rdata = DATA_W'(TX_DEPTH);
            A_RXD:   rdata = DATA_W'(RX_DEPTH);
            A_PMODE: begin
                rdata[1:0]       = CAP_BITS;
                rdata[BIT_IFACE] = iface_rs485;
            end
            A_PCTRL: begin
                rdata[1:0]         = wire_mode;
                rdata[BIT_XCVR_EN] = xcvr_en;
                rdata[BIT_TERM]    = term_en;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
    import rs485_dir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tx_fifo_nonempty,
    input  logic       tx_shift_busy,
    output dir_state_e state_q,
    output logic       talk_next
);

    dir_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LISTEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_LISTEN;
        if (run) begin
            unique case (state_q)
                ST_LISTEN: state_d = tx_fifo_nonempty ? ST_SEND : ST_LISTEN;
                ST_SEND: begin
                    if (tx_fifo_nonempty)   state_d = ST_SEND;
                    else if (tx_shift_busy) state_d = ST_DRAIN;
                    else                    state_d = ST_LISTEN;
                end
                ST_DRAIN: begin
                    if (tx_fifo_nonempty)   state_d = ST_SEND;
                    else if (tx_shift_busy) state_d = ST_DRAIN;
                    else                    state_d = ST_LISTEN;
                end
                default: state_d = ST_LISTEN;
            endcase
        end
    end

    assign talk_next = (state_d != ST_LISTEN);

endmodule

// File: rtl/rs485_dir_out.sv
module rs485_dir_out
    import rs485_dir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wire_mode_e wire_mode,
    input  logic       xcvr_en,
    input  logic       dtr_in,
    input  logic       auto_talk,
    output logic       drv_en,
    output logic       rcv_en
);

    logic de_d;
    logic re_d;

    always_comb begin
        de_d = 1'b0;
        re_d = 1'b0;
        if (xcvr_en) begin
            unique case (wire_mode)
                WM_FULL_DUPLEX: begin de_d = 1'b1;      re_d = 1'b1;       end
                WM_ECHO:        begin de_d = dtr_in;    re_d = 1'b1;       end
                WM_DTR_DIR:     begin de_d = dtr_in;    re_d = !dtr_in;    end
                WM_AUTO_DIR:    begin de_d = auto_talk; re_d = !auto_talk; end
                default:        begin de_d = 1'b0;      re_d = 1'b0;       end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_en <= 1'b0;
            rcv_en <= 1'b0;
        end else begin
            drv_en <= de_d;
            rcv_en <= re_d;
        end
    end

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int TX_DEPTH = 64,
    parameter int RX_DEPTH = 32,
    parameter int PORT_CAP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_fifo_nonempty,
    input  logic              tx_shift_busy,
    input  logic              dtr_in,
    input  logic              auto_dtr_en,
    input  logic              port_is_rs485,
    output logic              drv_en,
    output logic              rcv_en,
    output logic              term_en,
    output logic              dtr_out
);

    wire_mode_e wire_mode;
    logic       xcvr_en;
    logic       auto_talk;
    dir_state_e dir_state;

    rs485_dir_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .TX_DEPTH (TX_DEPTH),
        .RX_DEPTH (RX_DEPTH),
        .PORT_CAP (PORT_CAP)
    ) i_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr          (reg_addr),
        .we            (reg_we),
        .wdata         (reg_wdata),
        .rdata         (reg_rdata),
        .port_is_rs485 (port_is_rs485),
        .wire_mode     (wire_mode),
        .xcvr_en       (xcvr_en),
        .term_en       (term_en)
    );

    rs485_dir_fsm i_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .run              (xcvr_en && wire_mode == WM_AUTO_DIR),
        .tx_fifo_nonempty (tx_fifo_nonempty),
        .tx_shift_busy    (tx_shift_busy),
        .state_q          (dir_state),
        .talk_next        (auto_talk)
    );

    rs485_dir_out i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .wire_mode (wire_mode),
        .xcvr_en   (xcvr_en),
        .dtr_in    (dtr_in),
        .auto_talk (auto_talk),
        .drv_en    (drv_en),
        .rcv_en    (rcv_en)
    );

    assign dtr_out = (auto_dtr_en && wire_mode == WM_AUTO_DIR) ? drv_en : dtr_in;

endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int TX_DEPTH = 64,
    parameter int RX_DEPTH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        wire_mode,
    input logic              xcvr_en,
    input logic              dtr_in,
    input logic              tx_shift_busy,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              drv_en,
    input logic              rcv_en
);

    AST_FULL_DUPLEX_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (xcvr_en && wire_mode == 2'd0) |=> (drv_en && rcv_en));                 // R2

    AST_ECHO_FOLLOWS_DTR: assert property (@(posedge clk) disable iff (!rst_n)
        (xcvr_en && wire_mode == 2'd1) |=> (rcv_en && drv_en == $past(dtr_in))); // R3

    AST_HALF_DUPLEX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (xcvr_en && wire_mode[1]) |=> (drv_en != rcv_en));                      // R4

    AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (xcvr_en && wire_mode == 2'd3 && drv_en && tx_shift_busy) |=> drv_en);  // R6

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !xcvr_en |=> (!drv_en && !rcv_en));                                     // R7

    AST_TX_DEPTH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(12)) |-> (reg_rdata == DATA_W'(TX_DEPTH)));        // R9

    AST_RX_DEPTH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(13)) |-> (reg_rdata == DATA_W'(RX_DEPTH)));        // R9

endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TX_DEPTH (TX_DEPTH),
    .RX_DEPTH (RX_DEPTH)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wire_mode     (wire_mode),
    .xcvr_en       (xcvr_en),
    .dtr_in        (dtr_in),
    .tx_shift_busy (tx_shift_busy),
    .reg_addr      (reg_addr),
    .reg_rdata     (reg_rdata),
    .drv_en        (drv_en),
    .rcv_en        (rcv_en)
);

// File: tb/test_rs485_dir_ctrl.sv
`timescale 1ns/1ps
module test_rs485_dir_ctrl;

    localparam int TXD = 64;
    localparam int RXD = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tx_fifo_nonempty = 1'b0;
    logic       tx_shift_busy = 1'b0;
    logic       dtr_in = 1'b0;
    logic       auto_dtr_en = 1'b0;
    logic       port_is_rs485 = 1'b1;
    logic       drv_en, rcv_en, term_en, dtr_out;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    rs485_dir_ctrl #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .PORT_CAP(3)) i_rs485_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_fifo_nonempty(tx_fifo_nonempty), .tx_shift_busy(tx_shift_busy),
        .dtr_in(dtr_in), .auto_dtr_en(auto_dtr_en), .port_is_rs485(port_is_rs485),
        .drv_en(drv_en), .rcv_en(rcv_en), .term_en(term_en), .dtr_out(dtr_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 de in reset", {7'd0, drv_en}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'hF, v);
        chk("R1 pcr", v, 8'h03);
        chk("R1 de", {7'd0, drv_en}, 8'd0);
        chk("R1 re", {7'd0, rcv_en}, 8'd0);
        chk("R1 term", {7'd0, term_en}, 8'd0);

        // Sweep: R2 R3 R4 R5 R7 R8 R11
        for (int k = 0; k < 64; k++) begin
            logic [1:0] m;
            logic en, d, f, b, ad, term, ede, ere, edtr;
            m = k[1:0]; en = k[2]; d = k[3]; f = k[4]; b = k[5];
            ad = b ^ d;
            term = m[0] ^ en;
            tx_fifo_nonempty = 1'b0; tx_shift_busy = 1'b0;
            wr(4'hF, {1'b0, term, 2'b00, en, 1'b0, m});
            settle();
            dtr_in = d; tx_fifo_nonempty = f; tx_shift_busy = b; auto_dtr_en = ad;
            settle();
            if (!en) begin ede = 0; ere = 0; end
            else case (m)
                2'd0: begin ede = 1; ere = 1; end
                2'd1: begin ede = d; ere = 1; end
                2'd2: begin ede = d; ere = !d; end
                default: begin ede = f; ere = !f; end
            endcase
            edtr = (ad && m == 2'd3) ? ede : d;
            chk($sformatf("R2/R3/R4/R5/R7 de k=%0d", k), {7'd0, drv_en}, {7'd0, ede});
            chk($sformatf("R2/R3/R4/R5/R7 re k=%0d", k), {7'd0, rcv_en}, {7'd0, ere});
            chk($sformatf("R8 term k=%0d", k), {7'd0, term_en}, {7'd0, term});
            chk($sformatf("R11 dtr_out k=%0d", k), {7'd0, dtr_out}, {7'd0, edtr});
        end

        // R5 / R6: turn-around timing in automatic mode
        tx_fifo_nonempty = 0; tx_shift_busy = 0; dtr_in = 0; auto_dtr_en = 0;
        wr(4'hF, 8'h0B);
        settle();
        tx_fifo_nonempty = 1;
        #1;
        chk("R5 de not early", {7'd0, drv_en}, 8'd0);
        @(negedge clk);
        chk("R5 de after one edge", {7'd0, drv_en}, 8'd1);
        chk("R5 re blanked", {7'd0, rcv_en}, 8'd0);
        tx_fifo_nonempty = 0; tx_shift_busy = 1;
        @(negedge clk);
        chk("R6 de held drain", {7'd0, drv_en}, 8'd1);
        repeat (5) @(negedge clk);
        chk("R6 de held long", {7'd0, drv_en}, 8'd1);
        tx_shift_busy = 0;
        @(negedge clk);
        chk("R6 de released", {7'd0, drv_en}, 8'd0);
        chk("R6 re restored", {7'd0, rcv_en}, 8'd1);

        // R7: clearing enable while sending
        tx_fifo_nonempty = 1;
        settle();
        wr(4'hF, 8'h03);
        chk("R7 de one edge after write", {7'd0, drv_en}, 8'd1);
        @(negedge clk);
        chk("R7 de off", {7'd0, drv_en}, 8'd0);
        chk("R7 re off", {7'd0, rcv_en}, 8'd0);
        tx_fifo_nonempty = 0;

        // R8: writable bits
        wr(4'hF, 8'hFF);
        rd(4'hF, v);
        chk("R8 pcr mask", v, 8'h4B);
        chk("R8 term on", {7'd0, term_en}, 8'd1);
        wr(4'hF, 8'h00);
        rd(4'hF, v);
        chk("R8 pcr clear", v, 8'h00);

        // R9: read-only depths
        wr(4'hF, 8'h49);
        wr(4'hC, 8'h55);
        wr(4'hD, 8'hAA);
        wr(4'hE, 8'hFF);
        rd(4'hC, v);
        chk("R9 tx depth", v, 8'(TXD));
        rd(4'hD, v);
        chk("R9 rx depth", v, 8'(RXD));
        rd(4'hF, v);
        chk("R9 pcr untouched", v, 8'h49);

        // R10: port mode register
        port_is_rs485 = 1;
        rd(4'hE, v);
        chk("R10 pmr rs485", v, 8'h13);
        port_is_rs485 = 0;
        rd(4'hE, v);
        chk("R10 pmr rs232", v, 8'h03);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule